// File: doc/BRIEF.md
# Rotated-Recompute Checked ALU

This block is an N-bit arithmetic/logic unit that checks its own datapath by running each operation twice. The datapath is a ring of N+1 bit slices: N slices for the operand bits and one spare slice that always sees zero on both operand inputs. The first pass runs on the zero-extended operands as they are. The second pass rotates both operands left by K positions around the ring and runs them through the same slices. Its result is rotated right by K and compared with the first-pass word. Any difference raises the error flag.

The spare slice gives the second pass a working carry chain without any extra control. Its operand inputs are both zero, so it passes an incoming carry to its sum bit and never produces a carry of its own. Wherever rotation puts it, it therefore ends the chain, and the carry-out of the last physical slice can feed slice 0. In the first pass its sum bit is the adder carry-out. The outputs shown to the user come from the first pass. The second pass only feeds the comparison.

A test-only mask forces the sum output of any chosen set of physical slices to a stuck value. This makes it possible to show which adjacent fault bursts the rotation distance K catches.

Top module: `rro_checked_alu`

## Requirements
- R1: With op code 0 (add), `result_o` equals (a+b) mod 2^N and `carry_o` equals bit N of a+b.
- R2: Op code 1 gives a AND b, code 2 gives a OR b, code 3 gives a XOR b and code 4 gives NOT a. For all of these `carry_o` is 0.
- R3: A start that is sampled while the block is idle is accepted. `done_o` is then high for exactly one cycle, two rising edges after the accepting edge. A start that is sampled during the second pass is ignored and produces no further done.
- R4: When the force mask is zero during both passes, `err_o` is 0 when done is high.
- R5: For a logic op (codes 1 to 4), any adjacent burst of forced slices (wrapping around the ring) of length up to K mod N that makes the reported result wrong sets `err_o`. This assumes K ≤ N+1−(K mod N).
- R6: For add, any adjacent forced burst of length up to K−1 that makes the reported result or carry wrong sets `err_o`.
- R7: `result_o`, `carry_o` and `err_o` keep their values from done until the next accepted start, whatever the other inputs do.
- R8: After reset, `done_o`, `err_o`, `result_o` and `carry_o` are all 0.
- R9: Op codes 5 to 7 give a result of 0 and a carry of 0, and they never raise the error flag on their own.
- R10: With forcing active, the reported word equals the true (N+1)-bit word with forced slice positions replaced by the stuck value. `err_o` is set exactly when that word differs from the second-pass word recovered through the rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe; operands and op sampled with it |
| op_i | input | 3 | Operation code (0 add, 1 and, 2 or, 3 xor, 4 not a) |
| a_i | input | N | Operand A |
| b_i | input | N | Operand B |
| tst_force_mask_i | input | N+1 | Test only: one bit per physical slice whose sum is forced |
| tst_force_val_i | input | 1 | Test only: stuck value for forced slices |
| result_o | output | N | First-pass result |
| carry_o | output | 1 | First-pass carry-out (add only) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Mismatch between the two passes, held until next start |

## Verification
Two things can happen in the same cycle. The first is the second pass of one operation, where the comparison is made and done is about to rise. The second is a new start strobe. While done is high, a start is legal and is taken at once. One cycle earlier, during the second pass, a start must be ignored. The bench runs operations back to back, so every new start lands in the done cycle of the one before. It also raises start in the middle of the second pass with different operands, then checks that the first operation's result is still shown and that no second done pulse follows.

// File: rtl/rro_pkg.sv
package rro_pkg;

  typedef enum logic [2:0] {
    RRO_ADD  = 3'd0,
    RRO_AND  = 3'd1,
    RRO_OR   = 3'd2,
    RRO_XOR  = 3'd3,
    RRO_NOTA = 3'd4
  } rro_op_e;

  // One bit slice: returns {carry_out, sum}. Unused codes yield zero.
  function automatic logic [1:0] slice_eval(logic [2:0] op, logic a, logic b, logic cin);
    logic [1:0] r;
    case (op)
      RRO_ADD:  r = {(a & b) | (cin & (a ^ b)), a ^ b ^ cin};
      RRO_AND:  r = {1'b0, a & b};
      RRO_OR:   r = {1'b0, a | b};
      RRO_XOR:  r = {1'b0, a ^ b};
      RRO_NOTA: r = {1'b0, ~a};
      default:  r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rro_slice.sv
module rro_slice
  import rro_pkg::*;
(
  input  logic [2:0] op,
  input  logic       a,
  input  logic       b,
  input  logic       cin,
  input  logic       force_en,
  input  logic       force_val,
  output logic       s,
  output logic       cout
);
  logic [1:0] raw;

  always_comb begin
    raw  = slice_eval(op, a, b, cin);
    cout = raw[1];
    s    = force_en ? force_val : raw[0];
  end
endmodule

// File: rtl/rro_ring.sv
module rro_ring
  import rro_pkg::*;
#(
  parameter int W = 9
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a_w,
  input  logic [W-1:0] b_w,
  input  logic [W-1:0] force_mask,
  input  logic         force_val,
  output logic [W-1:0] sum_o,
  output logic         ok_o
);
  // Carry leaving the last physical slice, found by a carry-only lap that
  // starts from zero; the zero slice kills the carry, so this value is exact.
  function automatic logic lap_carry(logic [2:0] o, logic [W-1:0] x, logic [W-1:0] y);
    logic       c;
    logic [1:0] r;
    c = 1'b0;
    for (int i = 0; i < W; i++) begin
      r = slice_eval(o, x[i], y[i], c);
      c = r[1];
    end
    return c;
  endfunction

  logic [W:0] c;

  assign c[0] = lap_carry(op, a_w, b_w);

  for (genvar i = 0; i < W; i++) begin : g_slice
    rro_slice u_slice (
      .op        (op),
      .a         (a_w[i]),
      .b         (b_w[i]),
      .cin       (c[i]),
      .force_en  (force_mask[i]),
      .force_val (force_val),
      .s         (sum_o[i]),
      .cout      (c[i+1])
    );
  end

  // The carry closing the ring must agree with the one fed into slice 0.
  assign ok_o = (c[W] == c[0]);
endmodule

// File: rtl/rro_rotate.sv
module rro_rotate #(
  parameter int W    = 9,
  parameter int K    = 3,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int SH = K % W;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LEFT) begin : g_l
      assign q_o[(i + SH) % W] = d_i[i];
    end else begin : g_r
      assign q_o[i] = d_i[(i + SH) % W];
    end
  end
endmodule

// File: rtl/rro_seq.sv
module rro_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);
  assign accept_o = start_i & ~busy_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      busy_o <= accept_o;
      done_o <= busy_o;
    end
  end
endmodule

// File: rtl/rro_checked_alu.sv
module rro_checked_alu
  import rro_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N:0]   tst_force_mask_i,
  input  logic         tst_force_val_i,
  output logic [N-1:0] result_o,
  output logic         carry_o,
  output logic         done_o,
  output logic         err_o
);
  localparam int W = N + 1;

  logic         accept, busy;
  logic [N-1:0] a_q, b_q;
  logic [2:0]   op_q;
  logic [W-1:0] pass1_q;
  logic         err_q;

  logic [W-1:0] a_rot, b_rot, ring_a, ring_b, ring_sum, recovered;
  logic [2:0]   ring_op;
  logic         ring_ok, mismatch, fault_any;

  rro_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  rro_rotate #(.W(W), .K(K), .LEFT(1'b1)) u_rot_a (.d_i({1'b0, a_q}), .q_o(a_rot));
  rro_rotate #(.W(W), .K(K), .LEFT(1'b1)) u_rot_b (.d_i({1'b0, b_q}), .q_o(b_rot));

  // Pass one reads the ports, pass two the rotated captured operands.
  assign ring_a  = busy ? a_rot : {1'b0, a_i};
  assign ring_b  = busy ? b_rot : {1'b0, b_i};
  assign ring_op = busy ? op_q  : op_i;

  rro_ring #(.W(W)) u_ring (
    .op         (ring_op),
    .a_w        (ring_a),
    .b_w        (ring_b),
    .force_mask (tst_force_mask_i),
    .force_val  (tst_force_val_i),
    .sum_o      (ring_sum),
    .ok_o       (ring_ok)
  );

  rro_rotate #(.W(W), .K(K), .LEFT(1'b0)) u_rot_back (.d_i(ring_sum), .q_o(recovered));

  assign mismatch  = (recovered != pass1_q) | ~ring_ok;
  assign fault_any = |tst_force_mask_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      op_q    <= RRO_ADD;
      pass1_q <= '0;
      err_q   <= 1'b0;
    end else if (accept) begin
      a_q     <= a_i;
      b_q     <= b_i;
      op_q    <= op_i;
      pass1_q <= ring_sum;
      err_q   <= 1'b0;
    end else if (busy) begin
      err_q   <= mismatch;
    end
  end

  assign result_o = pass1_q[N-1:0];
  assign carry_o  = (op_q == RRO_ADD) & pass1_q[N];
  assign err_o    = err_q;
endmodule

// File: rtl/rro_alu_chk.sv
module rro_alu_chk
  import rro_pkg::*;
#(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy,
  input logic         done_o,
  input logic         err_o,
  input logic [N-1:0] result_o,
  input logic         carry_o,
  input logic [2:0]   op_q,
  input logic         fault_any,
  input logic         ring_ok
);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> busy);

  // R3
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done_o && !busy));

  // R4
  clean_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(fault_any) && !$past(fault_any, 2)) |-> !err_o);

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_i && !busy) |=> ($stable(result_o) && $stable(carry_o)));

  // R7
  hold_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(err_o));

  // R2
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_q != RRO_ADD) |-> !carry_o);

  // R1
  ring_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_ok);
endmodule

bind rro_checked_alu rro_alu_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy      (busy),
  .done_o    (done_o),
  .err_o     (err_o),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .op_q      (op_q),
  .fault_any (fault_any),
  .ring_ok   (ring_ok)
);

// File: tb/sim_rro_checked_alu.sv
module sim_rro_checked_alu;
  localparam int N = 4;
  localparam int K = 2;
  localparam int W = N + 1;
  localparam int LOGIC_LIM = K % N;
  localparam int ADD_LIM   = K - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic [N-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] mask_i = '0;
  logic         fval_i = 1'b0;
  logic [N-1:0] result_o;
  logic         carry_o, done_o, err_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rro_checked_alu #(.N(N), .K(K)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .tst_force_mask_i(mask_i), .tst_force_val_i(fval_i),
    .result_o(result_o), .carry_o(carry_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] true_word(logic [2:0] op, logic [N-1:0] a, logic [N-1:0] b);
    case (op)
      3'd0: return W'(a) + W'(b);
      3'd1: return {1'b0, a & b};
      3'd2: return {1'b0, a | b};
      3'd3: return {1'b0, a ^ b};
      3'd4: return {1'b1, ~a};
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] burst(int start, int len);
    logic [W-1:0] m = '0;
    for (int j = 0; j < len; j++) m[(start + j) % W] = 1'b1;
    return m;
  endfunction

  // Called at a falling edge; returns at the falling edge after done rises.
  task automatic run_op(input logic [2:0] op, input logic [N-1:0] a, input logic [N-1:0] b,
                        input logic [W-1:0] m, input logic v, input string req);
    logic [W-1:0] t, p1, p2;
    logic [N:0]   act, exp;
    logic         exp_err, rep_wrong;
    t = true_word(op, a, b);
    for (int i = 0; i < W; i++) begin
      p1[i] = m[i] ? v : t[i];
      p2[i] = m[(i + K) % W] ? v : t[i];
    end
    exp_err = (p1 != p2);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b; mask_i = m; fval_i = v;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    exp = {(op == 3'd0) ? p1[N] : 1'b0, p1[N-1:0]};
    act = {carry_o, result_o};
    check(done_o === 1'b1 && act === exp && err_o === exp_err, req,
          {27'd0, done_o, err_o, 3'd0} | 32'(act), {27'd0, 1'b1, exp_err, 3'd0} | 32'(exp));
    rep_wrong = (exp != {(op == 3'd0) ? t[N] : 1'b0, t[N-1:0]});
    if (m != '0 && rep_wrong)
      check(err_o === 1'b1, (op == 3'd0) ? "R6" : "R5", 32'(err_o), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(done_o === 1'b0 && err_o === 1'b0 && result_o === '0 && carry_o === 1'b0, "R8",
          {done_o, err_o, carry_o, result_o}, 0);

    // R1 R2 R9 R4 fault-free sweep, back-to-back starts
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          run_op(3'(op), N'(a), N'(b), '0, 1'b0,
                 op == 0 ? "R1/R4" : (op < 5 ? "R2/R4" : "R9"));

    // R3 start during pass two is ignored
    start_i = 1'b1; op_i = 3'd0; a_i = 4'd3; b_i = 4'd5; mask_i = '0;
    @(negedge clk);
    a_i = 4'd1; b_i = 4'd1;
    check(done_o === 1'b0, "R3", 32'(done_o), 0);
    @(negedge clk);
    start_i = 1'b0;
    check(done_o === 1'b1 && result_o === 4'd8 && carry_o === 1'b0, "R3",
          {done_o, carry_o, result_o}, {2'b10, 4'd8});
    @(negedge clk);
    check(done_o === 1'b0, "R3", 32'(done_o), 0);
    @(negedge clk);
    check(done_o === 1'b0 && result_o === 4'd8, "R3", {done_o, result_o}, 32'd8);

    // R7 outputs held while idle, inputs moving
    a_i = 4'hF; b_i = 4'hF; op_i = 3'd4;
    repeat (3) @(negedge clk);
    check(result_o === 4'd8 && carry_o === 1'b0 && err_o === 1'b0, "R7",
          {err_o, carry_o, result_o}, 32'd8);
    run_op(3'd1, 4'hF, 4'hF, burst(0, 1), 1'b0, "R10");
    mask_i = '0; a_i = 4'h0;
    repeat (3) @(negedge clk);
    check(err_o === 1'b1 && result_o === 4'hE, "R7", {err_o, result_o}, {1'b1, 4'hE});

    // R5 R10 logic bursts up to K mod N
    for (int op = 1; op < 5; op++)
      for (int len = 1; len <= LOGIC_LIM; len++)
        for (int s = 0; s < W; s++)
          for (int v = 0; v < 2; v++)
            for (int a = 0; a < (1 << N); a++)
              for (int b = 0; b < (1 << N); b++)
                run_op(3'(op), N'(a), N'(b), burst(s, len), 1'(v), "R10");

    // R6 R10 add bursts up to K-1
    for (int len = 1; len <= ADD_LIM; len++)
      for (int s = 0; s < W; s++)
        for (int v = 0; v < 2; v++)
          for (int a = 0; a < (1 << N); a++)
            for (int b = 0; b < (1 << N); b++)
              run_op(3'd0, N'(a), N'(b), burst(s, len), 1'(v), "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 180000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected<180000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule